// File: doc/BRIEF.md
# MCU Reset Isolation Word Controller

This block keeps a 32-bit status word that software on the MCU side writes, and uses that word to decide whether warm resets coming from the main power domain reach the MCU core. While the word is zero, every main-domain warm reset request also resets the MCU core. Once software stores any nonzero value, those warm resets are kept away from the core, so the MCU keeps running while the main domain restarts. Only the MCU power-on reset clears the word. That reset always reaches the core, and nothing can block it.

The word is written through a simple MCU-side port with byte strobes and read back on the same port. A second, read-only port mirrors the word so that main-domain boot software can see whether the MCU core is already running with isolation enabled. The isolation decision comes from a registered "word is nonzero" flag, so the gating term has no glitches. The gated core reset asserts asynchronously and is released through a synchroniser in the MCU clock domain.

Top module: `rstiso_ctrl`

## Requirements
- R1: While `por_n` is low, `cfg_rdata` and `mir_rdata` read 0 and `core_rst_n` is low.
- R2: A write with `cfg_we` high stores byte lane i (bits 8i+7:8i) of `cfg_wdata` wherever `cfg_be[i]` is 1 and keeps the other lanes. All 32 bits read back exactly on `cfg_rdata` after that rising edge.
- R3: `mir_rdata` always equals the stored word. It reads 0 when the word is 0. `mir_we` and `mir_wdata` have no effect on the word.
- R4: While the isolation flag is clear, any bit of `warm_req_n` going low drives `core_rst_n` low at once, without waiting for a clock edge.
- R5: The isolation flag is set on the second rising edge after the word becomes nonzero. Any nonzero value sets it. While it is set, `warm_req_n` has no effect on `core_rst_n`.
- R6: A warm reset request, whether blocked or passed, never changes the stored word.
- R7: `por_n` low drives `core_rst_n` low at once and clears the word, whatever the word holds.
- R8: After all reset sources go inactive, `core_rst_n` stays low through the first rising edge and goes high on the second rising edge.
- R9: If the write that takes the word from zero to nonzero lands on the same edge that a warm request arrives, the reset still reaches the core. Writing the word back to zero restores propagation once the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mcu | input | 1 | MCU domain clock |
| por_n | input | 1 | MCU power-on reset, active low |
| warm_req_n | input | 2 | Main-domain warm reset requests, active low, one per source |
| cfg_we | input | 1 | MCU-side write enable |
| cfg_be | input | 4 | MCU-side byte strobes |
| cfg_wdata | input | 32 | MCU-side write data |
| cfg_rdata | output | 32 | MCU-side read data (stored word) |
| mir_we | input | 1 | Write enable seen at the mirror port (ignored) |
| mir_wdata | input | 32 | Write data seen at the mirror port (ignored) |
| mir_rdata | output | 32 | Read-only mirror of the stored word |
| core_rst_n | output | 1 | Gated MCU core reset, active low |

## Verification
Warm requests are applied on each source separately and in random combinations, with the word at zero and at several nonzero values, including single-bit values. This shows that gating depends only on whether the word is zero. A power-on reset is applied over a nonzero word to show it cannot be blocked and that it clears the word. Random byte-strobed writes, mixed with ignored mirror-port writes and blocked warm pulses, show that the word is retained exactly. A write that lands on the same edge as a warm request tells the registered-flag timing apart from a combinational gate.

// File: rtl/rstiso_pkg.sv
package rstiso_pkg;
  parameter int unsigned RI_WORD_W  = 32;
  parameter int unsigned RI_NUM_SRC = 2;
  parameter int unsigned RI_STAGES  = 2;
endpackage

// File: rtl/rstiso_sync.sv
module rstiso_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rstiso_word.sv
module rstiso_word #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W/8-1:0] wr_be,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned LANES = WORD_W / 8;

  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_d;
  logic [LANES-1:0]  lane_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_en[g] = wr_en & wr_be[g];
    always_comb begin
      word_d[g*8 +: 8] = lane_en[g] ? wr_data[g*8 +: 8] : word_q[g*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         word_q <= '0;
    else if (|lane_en)  word_q <= word_d;
  end

  assign word_o = word_q;

  assert_hold_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && |wr_be) |=> $stable(word_o));

  assert_full_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && &wr_be) |=> (word_o == $past(wr_data)));
endmodule

// File: rtl/rstiso_gate.sv
module rstiso_gate #(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               por_n,
  input  logic [NUM_SRC-1:0] warm_req_n,
  input  logic [WORD_W-1:0]  word_i,
  output logic               iso_o,
  output logic               rst_src_n
);
  logic iso_q;
  logic iso_d;
  logic warm_any;

  always_comb begin
    iso_d    = |word_i;
    warm_any = ~&warm_req_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) iso_q <= 1'b0;
    else        iso_q <= iso_d;
  end

  assign iso_o     = iso_q;
  assign rst_src_n = por_n & ~(warm_any & ~iso_q);

  assert_flag_follows_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|word_i) |-> iso_o);
endmodule

// File: rtl/rstiso_ctrl.sv
module rstiso_ctrl
  import rstiso_pkg::*;
#(
  parameter int unsigned WORD_W  = RI_WORD_W,
  parameter int unsigned NUM_SRC = RI_NUM_SRC,
  parameter int unsigned STAGES  = RI_STAGES
) (
  input  logic                clk_mcu,
  input  logic                por_n,
  input  logic [NUM_SRC-1:0]  warm_req_n,
  input  logic                cfg_we,
  input  logic [WORD_W/8-1:0] cfg_be,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output logic [WORD_W-1:0]   cfg_rdata,
  input  logic                mir_we,
  input  logic [WORD_W-1:0]   mir_wdata,
  output logic [WORD_W-1:0]   mir_rdata,
  output logic                core_rst_n
);
  logic              por_sync_n;
  logic              rst_src_n;
  logic              iso;
  logic [WORD_W-1:0] word;

  rstiso_sync #(.STAGES(STAGES)) u_por_sync (
    .clk     (clk_mcu),
    .arst_n  (por_n),
    .rst_n_o (por_sync_n)
  );

  rstiso_word #(.WORD_W(WORD_W)) u_word (
    .clk     (clk_mcu),
    .rst_n   (por_sync_n),
    .wr_en   (cfg_we),
    .wr_be   (cfg_be),
    .wr_data (cfg_wdata),
    .word_o  (word)
  );

  rstiso_gate #(.WORD_W(WORD_W), .NUM_SRC(NUM_SRC)) u_gate (
    .clk        (clk_mcu),
    .rst_n      (por_sync_n),
    .por_n      (por_n),
    .warm_req_n (warm_req_n),
    .word_i     (word),
    .iso_o      (iso),
    .rst_src_n  (rst_src_n)
  );

  rstiso_sync #(.STAGES(STAGES)) u_core_sync (
    .clk     (clk_mcu),
    .arst_n  (rst_src_n),
    .rst_n_o (core_rst_n)
  );

  assign cfg_rdata = word;
  assign mir_rdata = word;

  assert_por_wins_R7: assert property (@(posedge clk_mcu)
    !por_n |-> (!core_rst_n && mir_rdata == '0));

  assert_warm_passes_R4: assert property (@(posedge clk_mcu) disable iff (!por_sync_n)
    (!iso && !(&warm_req_n)) |-> !core_rst_n);

  assert_warm_blocked_R5: assert property (@(posedge clk_mcu) disable iff (!por_sync_n)
    (iso && $past(core_rst_n)) |-> core_rst_n);

  assert_mirror_ignored_R3: assert property (@(posedge clk_mcu) disable iff (!por_sync_n)
    (mir_we && !cfg_we && mir_wdata != mir_rdata) |=> $stable(mir_rdata));
endmodule

// File: tb/rstiso_ctrl_tb.sv
module rstiso_ctrl_tb;
  logic        clk_mcu = 1'b0;
  logic        por_n;
  logic [1:0]  warm_req_n;
  logic        cfg_we;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        mir_we;
  logic [31:0] mir_wdata;
  logic [31:0] mir_rdata;
  logic        core_rst_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [31:0] model;

  always #4 clk_mcu = ~clk_mcu;

  rstiso_ctrl u_dut (
    .clk_mcu(clk_mcu), .por_n(por_n), .warm_req_n(warm_req_n),
    .cfg_we(cfg_we), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mir_we(mir_we), .mir_wdata(mir_wdata), .mir_rdata(mir_rdata),
    .core_rst_n(core_rst_n)
  );

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*8 +: 8] = d[i*8 +: 8];
    return r;
  endfunction

  function automatic logic exp_core_in_warm(input logic [31:0] w);
    return (w != 32'h0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_mcu);
    @(negedge clk_mcu);
  endtask

  task automatic wr(input logic [31:0] d, input logic [3:0] be);
    cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
    model = merge(model, d, be);
  endtask

  task automatic do_por();
    por_n = 1'b0;
    #1;
    chk("R7 core held by por", {31'b0, core_rst_n}, 32'h0);
    chk("R1 cfg_rdata in por", cfg_rdata, 32'h0);
    chk("R1 mir_rdata in por", mir_rdata, 32'h0);
    model = '0;
    tick();
    por_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    por_n = 1'b1; warm_req_n = 2'b11; cfg_we = 0; cfg_be = 0; cfg_wdata = 0;
    mir_we = 0; mir_wdata = 0; model = 0;
    #1;
    @(negedge clk_mcu);
    do_por();
    chk("R8 core released after por", {31'b0, core_rst_n}, 32'h1);

    // R4: each source alone with zero word
    for (int s = 0; s < 2; s++) begin
      warm_req_n = ~(2'b01 << s);
      #1;
      chk("R4 warm passes on zero word", {31'b0, core_rst_n}, 32'h0);
      tick();
      warm_req_n = 2'b11;
      tick();
      chk("R8 still low after first edge", {31'b0, core_rst_n}, 32'h0);
      tick();
      chk("R8 high after second edge", {31'b0, core_rst_n}, 32'h1);
    end

    // R2: partial byte writes
    wr(32'hA1B2_C3D4, 4'b0101);
    chk("R2 strobed write", cfg_rdata, 32'h00B2_00D4);
    wr(32'h1122_3344, 4'b1000);
    chk("R2 upper lane", cfg_rdata, 32'h11B2_00D4);
    // R3: mirror port writes ignored
    mir_we = 1'b1; mir_wdata = 32'hDEAD_BEEF;
    tick();
    mir_we = 1'b0;
    chk("R3 mirror write ignored", mir_rdata, 32'h11B2_00D4);
    wr(32'h0, 4'b1111);
    chk("R3 mirror reads zero", mir_rdata, 32'h0);

    // R5: single-bit nonzero word isolates
    wr(32'h0000_0100, 4'b0010);
    tick();
    warm_req_n = 2'b00;
    #1;
    chk("R5 warm blocked by nonzero word", {31'b0, core_rst_n}, 32'h1);
    repeat (3) tick();
    chk("R5 still running", {31'b0, core_rst_n}, 32'h1);
    chk("R6 word kept across blocked warm", cfg_rdata, 32'h0000_0100);
    warm_req_n = 2'b11;
    tick();

    // R7: por over nonzero word
    do_por();
    chk("R7 word cleared by por", cfg_rdata, 32'h0);

    // R9: write and warm on the same edge
    cfg_we = 1'b1; cfg_be = 4'hF; cfg_wdata = 32'h8000_0000;
    warm_req_n = 2'b10;
    #1;
    chk("R9 warm passes with same-edge write", {31'b0, core_rst_n}, 32'h0);
    tick();
    cfg_we = 1'b0; model = 32'h8000_0000;
    chk("R9 still in reset one edge later", {31'b0, core_rst_n}, 32'h0);
    warm_req_n = 2'b11;
    repeat (3) tick();
    chk("R6 word kept across passed warm", cfg_rdata, 32'h8000_0000);
    // R9: back to zero restores propagation
    wr(32'h0, 4'hF);
    tick();
    warm_req_n = 2'b01;
    #1;
    chk("R9 propagation restored", {31'b0, core_rst_n}, 32'h0);
    tick();
    warm_req_n = 2'b11;
    repeat (2) tick();

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom % 4;
      case (op)
        0: begin
          logic [31:0] d;
          d = ($urandom % 3 == 0) ? 32'h0 : $urandom;
          wr(d, 4'($urandom));
          chk("R2 random write", cfg_rdata, model);
          chk("R3 random mirror", mir_rdata, model);
        end
        1: begin
          mir_we = 1'b1; mir_wdata = $urandom;
          tick();
          mir_we = 1'b0;
          chk("R3 random mirror write ignored", mir_rdata, model);
        end
        2: begin
          logic [1:0] pat;
          logic       e;
          tick();
          pat = 2'($urandom);
          if (&pat) pat[0] = 1'b0;
          e = exp_core_in_warm(model);
          warm_req_n = pat;
          #1;
          chk(e ? "R5 random blocked" : "R4 random passed", {31'b0, core_rst_n}, {31'b0, e});
          tick();
          chk("R4/R5 random hold", {31'b0, core_rst_n}, {31'b0, e});
          warm_req_n = 2'b11;
          tick();
          chk("R8 random first edge", {31'b0, core_rst_n}, {31'b0, e});
          tick();
          chk("R8 random released", {31'b0, core_rst_n}, 32'h1);
          chk("R6 random word kept", cfg_rdata, model);
        end
        default: begin
          tick();
          chk("R8 idle running", {31'b0, core_rst_n}, 32'h1);
        end
      endcase
    end

    do_por();
    chk("R7 final por clears word", mir_rdata, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_mcu);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule